// File: doc/BRIEF.md
# Synchronous SRAM Cycle Controller

This block decodes the command pins of a synchronous single-port SRAM on every enabled rising clock edge. It also controls the data bus that belongs to that command. The command pins are three chip enables, a load/advance strobe, a write enable and active-low byte-write selects. Each command starts a cycle that is one of four kinds:

- a deselect;
- a burst read;
- a dummy read;
- a burst write.

The data phase of a command is the clock period after the edge that sampled it. During a read data phase the block drives the word stored at the sampled address, but only while the asynchronous output enable is active. During a write data phase it leaves the bus floating and captures the write data at the next enabled edge. Because of this pipelining, reads and writes can follow each other with no idle turnaround cycle.

A sibling sequencer supplies the address for every beat, including the burst-advance beats. This block only latches that address together with the command. The byte-lane strobes and the write address are delayed by one stage so that they line up with the write data. They then drive a behavioural memory array of parameterised depth. Each lane of that array holds eight data bits and one extra bit.

The clock enable is the only way to stall the block. While it is inactive, the edge has no effect at all. There is no valid/ready handshake and no back-pressure: the data bus is either driven or floating in each cycle, as the rules below decide.

Top module: `sram_cyc_ctl`

## Requirements
- R1: At an enabled edge with ld_n low, if ce1_n is high, ce2 is low or ce3_n is high, the new cycle is a deselect. In the following cycle dq_oe is 0.
- R2: At an enabled edge with ld_n high, ce1_n, ce2, ce3_n and we_n are ignored and the previous cycle kind continues:
  - a deselect stays a deselect;
  - a read stays a read;
  - a write stays a write.
- R3: At an enabled edge with ld_n low, all chip enables active and we_n high, a read starts. In the following cycle the block drives the stored word at the sampled address, with dq_oe 1, if oe_n is low. If oe_n is high it is a dummy read and dq_oe is 0.
- R4: At an enabled edge with ld_n low, all chip enables active and we_n low, a write starts. In the following cycle dq_oe is 0 whatever oe_n is. At the next enabled edge dq_in is stored into every lane whose bw_n bit was low at the command edge. If all bw_n bits were high, nothing is stored.
- R5: oe_n is not sampled by the clock. During a read data phase, dq_oe and dq_out follow oe_n combinationally within the same cycle.
- R6: An edge with cen_n high is ignored. The cycle kind, the latched address and the pending byte strobes are held, and no pending write data is stored at that edge.
- R7: After rst_n (asynchronous, active low) the block is in the deselect state and dq_oe is 0, even with oe_n low.
- R8: In each beat of a burst write, the bw_n bits sampled in that beat select the lanes written by that beat. Lane k occupies dq bits [9k+8:9k].
- R9: A read command can directly follow a write command, and the reverse also works, with no idle cycle between them. A read of an address just written returns the new data.
- R10: dq_out is all zeros in every cycle in which dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; high inserts a wait state |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low: start a new cycle; high: advance the current burst |
| we_n | input | 1 | Write enable, active low (read when high) |
| bw_n | input | LANES | Byte-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address for this beat, from the sequencer |
| dq_in | input | LANES*LANE_W | Write data, presented in the write data phase |
| dq_out | output | LANES*LANE_W | Read data, zero when not driving |
| dq_oe | output | 1 | Bus drive enable; low means the bus is tristated |

## Verification
A burst write is followed by a burst read of the same words, with a wait state placed inside each burst. This separates correct holding of the burst position from a design that advances or commits during a stalled edge. A second burst writes different lane subsets in each beat, and includes one beat with no lanes selected. The merged read-back shows whether the strobes are taken per beat and delayed by exactly one stage. Advance beats are driven with the chip enables and write enable toggled, and begin beats are driven with each chip enable made inactive in turn; together these distinguish decoding of the command pins from continuation of the current cycle kind. Back-to-back write/read pairs and a mid-cycle toggle of oe_n expose any turnaround bubble, a stale read, or an output enable that is sampled on the clock.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
  import sram_cyc_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output cyc_e             cyc_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] strb_q
);

  cyc_e nxt_cyc;
  logic sel_ok;

  assign sel_ok = !ce1_n && ce2 && !ce3_n;

  // A new cycle is decoded only on a load; an advance keeps the current kind.
  always_comb begin
    nxt_cyc = cyc_q;
    if (!ld_n) begin
      if (!sel_ok)    nxt_cyc = CYC_IDLE;
      else if (!we_n) nxt_cyc = CYC_WR;
      else            nxt_cyc = CYC_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_IDLE;
      addr_q <= '0;
      strb_q <= '0;
    end else if (!cen_n) begin
      cyc_q  <= nxt_cyc;
      addr_q <= addr;
      strb_q <= (nxt_cyc == CYC_WR) ? ~bw_n : '0;
    end
  end

  AST_CEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(cyc_q) && $stable(addr_q) && $stable(strb_q))); // R6

  AST_ADV_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && ld_n) |=> (cyc_q == $past(cyc_q))); // R2

  AST_DESEL_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !ld_n && (ce1_n || !ce2 || ce3_n)) |=> (cyc_q == CYC_IDLE)); // R1

  AST_STRB_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CYC_WR) |-> (strb_q == '0)); // R8

endmodule

// File: rtl/sram_cyc_array.sv
module sram_cyc_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        wr_strb,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_strb[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end

endmodule

// File: rtl/sram_cyc_bus.sv
module sram_cyc_bus
  import sram_cyc_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc_q,
  input  logic          oe_n,
  input  logic [DW-1:0] rd_data,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out
);

  // oe_n is used combinationally; write phases mask it entirely.
  assign dq_oe  = (cyc_q == CYC_RD) && !oe_n;
  assign dq_out = dq_oe ? rd_data : '0;

  AST_WR_BUS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_WR) |-> !dq_oe); // R4

  AST_IDLE_BUS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_IDLE) |-> (!dq_oe && dq_out == '0)); // R1

endmodule

// File: rtl/sram_cyc_ctl.sv
module sram_cyc_ctl
  import sram_cyc_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  cyc_e             cyc_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] strb_q;
  logic [DW-1:0]    rd_data;
  logic             commit;

  // The pending write completes at the next enabled edge, using this
  // cycle's data together with the strobes latched one stage earlier.
  assign commit = !cen_n && (cyc_q == CYC_WR);

  sram_cyc_decode #(.AW(AW), .LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .cyc_q(cyc_q), .addr_q(addr_q), .strb_q(strb_q)
  );

  sram_cyc_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(commit), .wr_addr(addr_q), .wr_strb(strb_q),
    .wr_data(dq_in), .rd_addr(addr_q), .rd_data(rd_data)
  );

  sram_cyc_bus #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .cyc_q(cyc_q), .oe_n(oe_n),
    .rd_data(rd_data), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  AST_OE_MASKED_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && cyc_q == CYC_WR) |=> !dq_oe); // R6

endmodule

// File: tb/sram_cyc_ctl_tb.sv
`timescale 1ns/1ps
module sram_cyc_ctl_tb_top;
  import sram_cyc_pkg::*;

  localparam int AW = 6, LANES = 2, LANE_W = 9, DW = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, ld_n = 1'b0, we_n = 1'b1;
  logic [LANES-1:0] bw_n = '1;
  logic oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  sram_cyc_ctl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Reference model built from the requirements.
  logic [DW-1:0] mmem [1<<AW];
  cyc_e m_cyc = CYC_IDLE;
  logic [AW-1:0] m_addr = '0;
  logic [LANES-1:0] m_strb = '0;

  logic [DW:0] exp_q [$];
  string req_q [$];

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual oe=%0b data=%h expected oe=%0b data=%h",
               req, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic beat(input logic cen, input logic ld, input logic c1n, input logic c2,
                      input logic c3n, input logic wen, input logic [LANES-1:0] bwn,
                      input logic oen, input logic [AW-1:0] a, input logic [DW-1:0] din,
                      input string req);
    logic drv;
    @(negedge clk);
    cen_n = cen; ld_n = ld; ce1_n = c1n; ce2 = c2; ce3_n = c3n; we_n = wen;
    bw_n = bwn; oe_n = oen; addr = a; dq_in = din;
    if (!cen) begin
      if (m_cyc == CYC_WR)
        for (int l = 0; l < LANES; l++)
          if (m_strb[l]) mmem[m_addr][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
      if (!ld) begin
        if (c1n || !c2 || c3n) m_cyc = CYC_IDLE;
        else if (!wen)         m_cyc = CYC_WR;
        else                   m_cyc = CYC_RD;
      end
      m_addr = a;
      m_strb = (m_cyc == CYC_WR) ? ~bwn : '0;
    end
    drv = (m_cyc == CYC_RD) && !oen;
    exp_q.push_back({drv, drv ? mmem[m_addr] : {DW{1'b0}}});
    req_q.push_back(req);
  endtask

  // Monitor: one expected item per clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [DW:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {dq_oe, dq_out}, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [DW-1:0] DA = 18'h2A5A5, DB = 18'h15A5A, DC = 18'h3C3C3,
                            DD = 18'h01234, DE = 18'h3FFFF, DF = 18'h0F0F0,
                            DG = 18'h11111, DH = 18'h2BEEF, DI = 18'h1CAFE;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R7 reset deselect", {dq_oe, dq_out}, {1'b0, {DW{1'b0}}});
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 after release", {dq_oe, dq_out}, {1'b0, {DW{1'b0}}});

    // burst write 5,6,7 with advance beats that wiggle CE/WE (ignored)
    beat(0,0,0,1,0,0,2'b00,0,6'd5,'0,"R4 write begin, bus float");
    beat(0,1,1,0,1,1,2'b00,0,6'd6,DA,"R2 advance ignores CE/WE");
    beat(0,1,0,1,0,1,2'b00,0,6'd7,DB,"R2 write continues");
    // read burst directly after the write, with a wait state inside
    beat(0,0,0,1,0,1,2'b11,0,6'd5,DC,"R9 read right after write");
    beat(0,1,0,1,0,1,2'b11,0,6'd6,'0,"R3 burst read beat");
    beat(1,1,0,1,0,0,2'b00,0,6'd7,'0,"R6 wait state holds read");
    beat(0,1,0,1,0,1,2'b11,0,6'd7,'0,"R3 read resumes after wait");
    // per-beat lane selection, wait state inside a write burst
    beat(0,0,0,1,0,0,2'b01,0,6'd5,'0,"R4 write masks oe_n");
    beat(0,1,0,1,0,1,2'b10,0,6'd6,DD,"R8 lane1 then lane0");
    beat(1,1,0,1,0,1,2'b00,0,6'd7,DE,"R6 wait state no commit");
    beat(0,1,0,1,0,1,2'b11,0,6'd7,DF,"R4 no lanes selected");
    beat(0,0,0,1,0,1,2'b11,0,6'd5,DG,"R8 merged lane read");
    beat(0,1,0,1,0,1,2'b11,0,6'd6,'0,"R8 merged lane read");
    beat(0,1,0,1,0,1,2'b11,0,6'd7,'0,"R4 empty-strobe beat kept data");
    // dummy reads
    beat(0,0,0,1,0,1,2'b11,1,6'd5,'0,"R3 dummy read");
    beat(0,1,0,1,0,1,2'b11,1,6'd6,'0,"R3 dummy read continues");
    // asynchronous output enable inside a read data phase
    beat(0,0,0,1,0,1,2'b11,0,6'd6,'0,"R5 read before oe toggle");
    @(posedge clk);
    #2.5;
    oe_n = 1'b1;
    #0.5;
    check("R5 oe_n high mid-cycle", {dq_oe, dq_out}, {1'b0, {DW{1'b0}}});
    check("R10 zero data when floating", {1'b0, dq_out}, {1'b0, {DW{1'b0}}});
    oe_n = 1'b0;
    #0.5;
    check("R5 oe_n low mid-cycle", {dq_oe, dq_out}, {1'b1, mmem[6]});
    // deselects and their continuation
    beat(0,0,1,1,0,1,2'b11,0,6'd5,'0,"R1 ce1_n inactive");
    beat(0,1,0,1,0,1,2'b11,0,6'd5,'0,"R2 deselect continues");
    beat(0,1,0,1,0,0,2'b00,0,6'd5,'0,"R2 deselect ignores WE");
    beat(0,0,0,0,0,1,2'b11,0,6'd5,'0,"R1 ce2 inactive");
    beat(0,0,0,1,1,1,2'b11,0,6'd5,'0,"R1 ce3_n inactive");
    beat(0,1,0,1,0,1,2'b11,0,6'd6,DE,"R1 no commit after deselect");
    // back-to-back write/read with no turnaround
    beat(0,0,0,1,0,0,2'b00,0,6'd8,'0,"R9 write 8");
    beat(0,0,0,1,0,1,2'b11,0,6'd8,DH,"R9 read 8 next cycle");
    beat(0,0,0,1,0,0,2'b00,0,6'd9,'0,"R9 write after read");
    beat(0,0,0,1,0,1,2'b11,0,6'd9,DI,"R9 read 9");
    beat(0,0,0,1,0,1,2'b11,0,6'd5,'0,"R9 read 5");
    beat(0,0,1,1,0,1,2'b11,0,6'd5,'0,"R1 final deselect");
    repeat (3) @(posedge clk);
    #3;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule